// File: doc/BRIEF.md
# Video clamp pulse generator

This block produces one clamp strobe per horizontal line of a display sync stream. It watches a positive-going horizontal drive pulse and places a programmable-width strobe either inside the sync tip or in the back porch that follows it. The position is chosen by a select input. In automatic mode the position depends on which sync source has been detected. During the vertical drive interval the strobe is suppressed when the line timing comes from a composite or sync-on-video source. It keeps running through that interval when separate horizontal and vertical sync are in use.

Both the delay from the horizontal drive edge to the strobe and the strobe width are counts of the system clock. Both values are captured when a strobe is launched. The strobe is driven on two pins of opposite polarity, so it can feed clamps of either sense. All inputs are synchronous to the single clock.

Top module: `clamp_pulse_gen`

## Requirements
- R1: With `pos_sel` = 2'b00 (back porch), a strobe is launched only by a falling edge of `hd`, meaning `hd` sampled 0 at an edge where it was 1 at the previous edge.
- R2: With `pos_sel` = 2'b01 (sync interval), a strobe is launched only by a rising edge of `hd`.
- R3: With `pos_sel[1]` = 1 (automatic), a strobe is launched on the rising edge of `hd` when `cs_present` is 1. When `cs_present` is 0 it is launched on the falling edge, whether or not any other source is present.
- R4: While `vd` = 1 and `src_sep` = 0, no strobe is launched. A strobe in progress is cancelled at the first clock edge that samples this condition.
- R5: While `src_sep` = 1, `vd` has no effect: strobes are launched and run to their full width as usual.
- R6: A launched strobe stays high for exactly `cfg_width` clock cycles. A launching edge seen while `cfg_width` = 0 produces no strobe and leaves a strobe in progress untouched.
- R7: `clamp_p` rises `cfg_delay` cycles after the clock edge that samples the launching `hd` transition. With a delay of 0 it is high in the cycle right after that edge.
- R8: `clamp_n` is always the inverse of `clamp_p`.
- R9: A launching edge that arrives while a strobe is pending or high restarts the timing from the new edge. The current strobe ends at once.
- R10: Delay and width are captured at launch. Changing `cfg_delay` or `cfg_width` afterwards does not alter the strobe in progress.
- R11: During and just after reset, `clamp_p` is 0 and `clamp_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd | input | 1 | Horizontal drive pulse, high during sync |
| vd | input | 1 | Vertical drive pulse, high during the vertical interval |
| src_sep | input | 1 | 1 when separate horizontal/vertical sync is the active source |
| cs_present | input | 1 | 1 when a composite or horizontal sync input is detected |
| pos_sel | input | 2 | 00 back porch, 01 sync interval, 1x automatic |
| cfg_delay | input | DLY_W | Edge-to-strobe delay in clock cycles |
| cfg_width | input | WID_W | Strobe width in clock cycles, 0 disables |
| clamp_p | output | 1 | Clamp strobe, active high |
| clamp_n | output | 1 | Clamp strobe, active low |

## Verification
The bench builds the block with a 4-bit delay field and a 5-bit width field. With these small fields the largest setting, a 15-cycle delay followed by a 31-cycle strobe, plays out within one short line. That exercises the top of the internal counter range. The same sizes keep retrigger cases short: a train of horizontal edges spaced closer than delay plus width fits in a few dozen cycles. Cancellation by the vertical interval lands in the middle of a strobe, and a configuration change issued during a strobe can be checked against the captured values.

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int DLY_W = 6,
  parameter int WID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd,
  input  logic             vd,
  input  logic             src_sep,
  input  logic             cs_present,
  input  logic [1:0]       pos_sel,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [WID_W-1:0] cfg_width,
  output logic             clamp_p,
  output logic             clamp_n
);

  localparam int CNT_W = ((DLY_W > WID_W) ? DLY_W : WID_W) + 1;
  localparam logic [1:0] SEL_BP   = 2'b00;
  localparam logic [1:0] SEL_SYNC = 2'b01;

  logic             hd_q;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [DLY_W-1:0] dly_lat;
  logic [WID_W-1:0] wid_lat;

  wire hd_rise  = hd & ~hd_q;
  wire hd_fall  = ~hd & hd_q;
  wire use_sync = (pos_sel == SEL_SYNC) | (pos_sel[1] & cs_present);
  wire blank    = vd & ~src_sep;
  wire edge_hit = use_sync ? hd_rise : hd_fall;
  wire fire     = edge_hit & ~blank & (cfg_width != '0);

  wire [CNT_W-1:0] last_cnt = CNT_W'(dly_lat) + CNT_W'(wid_lat) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd_q    <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      dly_lat <= '0;
      wid_lat <= '0;
    end else begin
      hd_q <= hd;
      if (blank) begin
        busy <= 1'b0;
      end else if (fire) begin
        busy    <= 1'b1;
        cnt     <= '0;
        dly_lat <= cfg_delay;
        wid_lat <= cfg_width;
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == last_cnt) busy <= 1'b0;
      end
    end
  end

  assign clamp_p = busy & (cnt >= CNT_W'(dly_lat));
  assign clamp_n = ~clamp_p;

  AST_BP_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_sel == SEL_BP && !hd_fall && !busy) |=> !busy); // R1
  AST_SYNC_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_sel == SEL_SYNC && !hd_rise && !busy) |=> !busy); // R2
  AST_AUTO_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_sel[1] && cs_present && !hd_rise && !busy) |=> !busy); // R3
  AST_VBLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (vd && !src_sep) |=> !clamp_p); // R4
  AST_SEP_RUNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sep && busy && cnt != last_cnt) |=> busy); // R5
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == '0 && !busy) |=> !busy); // R6
  AST_DELAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_delay == '0) |=> clamp_p); // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_delay != '0) |=> (busy && !clamp_p)); // R9

endmodule

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;
  localparam int CLK_NS = 10;
  localparam int DW = 4;
  localparam int WW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hd = 1'b0, vd = 1'b0, src_sep = 1'b0, cs_present = 1'b0;
  logic [1:0] pos_sel = 2'b00;
  logic [DW-1:0] cfg_delay = '0;
  logic [WW-1:0] cfg_width = '0;
  logic clamp_p, clamp_n;

  clamp_pulse_gen #(.DLY_W(DW), .WID_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .src_sep(src_sep),
    .cs_present(cs_present), .pos_sel(pos_sel), .cfg_delay(cfg_delay),
    .cfg_width(cfg_width), .clamp_p(clamp_p), .clamp_n(clamp_n));

  always #(CLK_NS/2) clk = ~clk;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb[$];
  int vectors = 0, fails = 0;
  string cur_tag = "R11";

  logic [1:0] n_sel = 2'b00;
  logic n_cs = 1'b0, n_sep = 1'b0;
  int n_d = 0, n_w = 0;

  bit m_hd = 1'b0, m_valid = 1'b0;
  int m_age = 0, m_d = 0, m_w = 0;

  task automatic step(input logic hd_v, input logic vd_v);
    bit sync_m, trig, blank;
    @(negedge clk);
    hd = hd_v; vd = vd_v; pos_sel = n_sel; cs_present = n_cs; src_sep = n_sep;
    cfg_delay = DW'(n_d); cfg_width = WW'(n_w);
    sync_m = (n_sel == 2'b01) || (n_sel[1] && n_cs);
    trig   = sync_m ? (hd_v && !m_hd) : (!hd_v && m_hd);
    blank  = vd_v && !n_sep;
    if (blank) m_valid = 1'b0;
    else if (trig && n_w != 0) begin
      m_valid = 1'b1; m_age = 0; m_d = n_d; m_w = n_w;
    end else if (m_valid) begin
      m_age++;
      if (m_age >= m_d + m_w) m_valid = 1'b0;
    end
    m_hd = hd_v;
    sb.push_back('{exp: (m_valid && m_age >= m_d), tag: cur_tag});
  endtask

  task automatic line(input int hlen, input int gap, input logic v);
    repeat (hlen) step(1'b1, v);
    repeat (gap) step(1'b0, v);
  endtask

  always begin
    item_t it;
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      vectors++;
      if (clamp_p !== it.exp) begin
        fails++;
        $display("FAIL %s: clamp_p=%b expected %b at %0t", it.tag, clamp_p, it.exp, $time);
      end
      if (clamp_n !== ~it.exp) begin
        fails++;
        $display("FAIL R8: clamp_n=%b expected %b at %0t", clamp_n, ~it.exp, $time);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    vectors++;
    if (clamp_p !== 1'b0 || clamp_n !== 1'b1) begin
      fails++;
      $display("FAIL R11: clamp_p/n=%b%b expected 01", clamp_p, clamp_n);
    end
    rst_n = 1'b1;

    cur_tag = "R11"; line(0, 3, 1'b0);
    // R1 back porch
    cur_tag = "R1"; n_sel = 2'b00; n_d = 3; n_w = 5;
    line(6, 20, 1'b0); line(6, 20, 1'b0);
    // R2 sync interval
    cur_tag = "R2"; n_sel = 2'b01;
    line(6, 20, 1'b0); line(6, 20, 1'b0);
    // R7 zero delay in both positions
    cur_tag = "R7"; n_d = 0; n_w = 2; line(4, 10, 1'b0);
    n_sel = 2'b00; n_w = 1; line(4, 10, 1'b0);
    // R3 automatic
    cur_tag = "R3"; n_sel = 2'b10; n_cs = 1'b1; n_d = 1; n_w = 3; line(5, 12, 1'b0);
    n_sel = 2'b11; n_cs = 1'b0; line(5, 12, 1'b0);
    n_sel = 2'b10; line(5, 12, 1'b0);
    // R6 width
    cur_tag = "R6"; n_w = 0; n_sel = 2'b01; line(5, 12, 1'b0);
    n_sel = 2'b00; line(5, 12, 1'b0);
    n_w = 1; line(3, 8, 1'b0);
    n_sel = 2'b01; n_d = 15; n_w = 31; line(3, 50, 1'b0);
    n_d = 2; n_w = 8; step(1'b1, 1'b0); step(1'b0, 1'b0);
    n_w = 0; step(1'b1, 1'b0); repeat (14) step(1'b0, 1'b0);
    // R4 blanking for composite / sync-on-video
    cur_tag = "R4"; n_sep = 1'b0; n_d = 1; n_w = 4; line(3, 10, 1'b1);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b1); step(1'b0, 1'b1); repeat (10) step(1'b0, 1'b0);
    // R5 separate sync ignores vd
    cur_tag = "R5"; n_sep = 1'b1; line(3, 10, 1'b1);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b1);
    repeat (10) step(1'b0, 1'b0);
    // R9 retrigger
    cur_tag = "R9"; n_sep = 1'b0; n_d = 2; n_w = 10;
    repeat (3) line(2, 3, 1'b0);
    line(0, 20, 1'b0);
    n_d = 0; n_w = 6; line(1, 2, 1'b0); line(1, 12, 1'b0);
    // R10 captured configuration
    cur_tag = "R10"; n_d = 2; n_w = 6; step(1'b1, 1'b0);
    n_d = 9; n_w = 1; repeat (14) step(1'b0, 1'b0);
    line(3, 16, 1'b0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule